// File: doc/BRIEF.md
# Corrected Packet Payload Read Port

This block holds one packet that an upstream stage has already error-corrected and lets a host processor read back only the payload of that packet. A packet is 272 bits wide. The 176-bit data block sits in the upper bits, and the lower 96 bits hold a 14-bit link CRC followed by 82 parity bits. The write side captures a whole packet in one load cycle and keeps only the data block. The check and parity bits are discarded there and can never reach the host bus.

The host reads through a microprocessor-style bus. This bus has an active-low chip select, an active-low read strobe, a 4-bit register address and a 16-bit data output. Payload reads use address 0. Each completed read returns the next bytes of the payload, taken in order from the leading byte. A width select picks either 8-bit or 16-bit reads. A ready output tells the host when the data is valid. It has two timing modes: in the second mode one wait state is added.

Once all 22 payload bytes have been read, further reads return zero and a sticky drained flag is set. The next packet load clears that flag and rewinds the pointer to the first byte.

The access controller has three states:
- `ACC_IDLE`: no read is active.
- `ACC_HOLD`: the wait state, used only in the second ready mode.
- `ACC_VALID`: ready is asserted.

It has five transitions:
- IDLE→VALID: an access starts while the ready mode is 0.
- IDLE→HOLD: an access starts while the ready mode is 1.
- HOLD→VALID: the access is still active.
- HOLD→IDLE: the access ends early.
- VALID→IDLE: the access ends.

The read pointer advances on the cycle where the strobe returns high after a HOLD or VALID state, provided chip select is still low and the address is still 0.

Top module: `payload_rd_port`

## Requirements
- R1: After reset, `rdy` is 0, `data_out` is 0 and `drained` is 1.
- R2: A `pkt_load` pulse stores `pkt_data[271:96]` as the payload, with byte k equal to `pkt_data[271-8k -: 8]` for k = 0..21. Bits [95:0] (the CRC and parity fields) never appear on `data_out`.
- R3: With `wide_sel`=0, an active read drives `data_out` = {8'h00, byte p}, where p is the read pointer.
- R4: With `wide_sel`=1, an active read drives `data_out` = {byte p, byte p+1}, so the earlier byte is on bits [15:8]. A byte index of 22 or more reads as zero.
- R5: A read is active only while `cs_n`=0, `rd_n`=0 and `addr`=0. In any other case `data_out` is 0, `rdy` stays 0 and the pointer does not move.
- R6: When `rd_n` rises with `cs_n`=0 and `addr`=0 after an active read, the pointer advances by 1 (`wide_sel`=0) or 2 (`wide_sel`=1) on that clock edge. The pointer saturates at 22.
- R7: When the pointer reaches 22, `drained` becomes 1 and stays 1 until the next load. Reads in this condition return 0.
- R8: `pkt_load` sets the pointer to 0 and `drained` to 0 on the next edge. A load takes priority over an advance in the same cycle.
- R9: With `rdy_mode`=0, `rdy` rises at the first clock edge where an active read is sampled. With `rdy_mode`=1, it rises one edge later.
- R10: `rdy` falls at the first clock edge where the read is no longer active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_load | input | 1 | One-cycle strobe that captures a corrected packet |
| pkt_data | input | 272 | Corrected packet: payload in [271:96], CRC and parity in [95:0] |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | 4 | Register address; payload reads use 0 |
| wide_sel | input | 1 | 0: 8-bit reads, 1: 16-bit reads |
| rdy_mode | input | 1 | 0: ready with no wait state, 1: ready after one wait state |
| data_out | output | 16 | Read data, zero when no read is active |
| rdy | output | 1 | Read data valid |
| drained | output | 1 | Sticky flag: the whole payload has been read, or no packet has been loaded yet |

## Verification
The assertions assume that the bus inputs are synchronous to `clk` and stable for at least one clock edge per phase. They also assume that `wide_sel` and `rdy_mode` do not change in the middle of an access, and that the host holds `cs_n` low and `addr` at 0 until the strobe has returned high. The bench drives every input on the falling clock edge and keeps each strobe phase for at least one full cycle. It changes width and ready mode only between accesses, so every check stays within these assumptions. The deliberately ignored accesses, with a non-zero address or chip select high, are still built from whole-cycle phases.

// File: rtl/prp_pkg.sv
package prp_pkg;
    localparam int BYTE_W = 8;
    localparam int BUS_W  = 16;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_HOLD  = 2'd1,
        ACC_VALID = 2'd2
    } acc_state_t;
endpackage

// File: rtl/prp_payload_store.sv
module prp_payload_store
    import prp_pkg::*;
#(
    parameter int PKT_BITS = 272,
    parameter int PAY_BITS = 176,
    parameter int PTR_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [PKT_BITS-1:0] pkt_data,
    input  logic [PTR_W-1:0]    ptr,
    input  logic                wide,
    input  logic                active,
    output logic [BUS_W-1:0]    data_out
);
    localparam int PAY_BYTES = PAY_BITS / BYTE_W;
    localparam int SH_W      = PTR_W + 3;

    logic [PAY_BITS-1:0] payload;
    logic [PAY_BITS-1:0] shifted;
    logic [BYTE_W-1:0]   hi_byte;
    logic [BYTE_W-1:0]   lo_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            payload <= '0;
        end else if (load) begin
            payload <= pkt_data[PKT_BITS-1 -: PAY_BITS];
        end
    end

    always_comb begin
        shifted = payload << SH_W'({ptr, 3'b000});
        hi_byte = shifted[PAY_BITS-1 -: BYTE_W];
        lo_byte = shifted[PAY_BITS-1-BYTE_W -: BYTE_W];
        if (!active) begin
            data_out = '0;
        end else if (wide) begin
            data_out = {hi_byte, lo_byte};
        end else begin
            data_out = {{(BUS_W-BYTE_W){1'b0}}, hi_byte};
        end
    end

    AST_ZERO_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr >= PTR_W'(PAY_BYTES)) |-> (data_out == '0)); // R7
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (data_out == '0)); // R5
endmodule

// File: rtl/prp_read_ptr.sv
module prp_read_ptr #(
    parameter int PAY_BYTES = 22,
    parameter int PTR_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic             wide,
    output logic [PTR_W-1:0] ptr,
    output logic             drained
);
    localparam logic [PTR_W:0]   LIMIT_X = (PTR_W+1)'(PAY_BYTES);
    localparam logic [PTR_W-1:0] LIMIT   = PTR_W'(PAY_BYTES);

    logic [PTR_W:0]   sum;
    logic [PTR_W-1:0] ptr_next;

    always_comb begin
        sum      = {1'b0, ptr} + (wide ? (PTR_W+1)'(2) : (PTR_W+1)'(1));
        ptr_next = (sum >= LIMIT_X) ? LIMIT : sum[PTR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr     <= '0;
            drained <= 1'b1;
        end else if (load) begin
            ptr     <= '0;
            drained <= 1'b0;
        end else if (advance) begin
            ptr     <= ptr_next;
            drained <= drained | (ptr_next == LIMIT);
        end
    end

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LIMIT); // R6
    AST_LOAD_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr == '0) && !drained); // R8
    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && (ptr < LIMIT - PTR_W'(2))) |=>
            (ptr == $past(ptr) + ($past(wide) ? PTR_W'(2) : PTR_W'(1)))); // R6
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(ptr)); // R5
    AST_DRAINED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (drained && !load) |=> drained); // R7
endmodule

// File: rtl/prp_access_fsm.sv
module prp_access_fsm
    import prp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic [3:0] addr,
    input  logic       rdy_mode,
    output logic       active,
    output logic       advance,
    output logic       rdy
);
    acc_state_t state, state_nx;
    logic       selected;

    always_comb begin
        selected = !cs_n && (addr == 4'd0);
        active   = selected && !rd_n;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ACC_IDLE:  if (active) state_nx = rdy_mode ? ACC_HOLD : ACC_VALID;
            ACC_HOLD:  state_nx = active ? ACC_VALID : ACC_IDLE;
            ACC_VALID: if (!active) state_nx = ACC_IDLE;
            default:   state_nx = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ACC_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        rdy     = (state == ACC_VALID);
        advance = (state != ACC_IDLE) && selected && rd_n;
    end

    AST_WAIT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ACC_IDLE && active && rdy_mode) |=> !rdy); // R9
    AST_FAST_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ACC_IDLE && active && !rdy_mode) |=> rdy); // R9
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !rdy); // R10
    AST_ADV_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> $past(active)); // R6
endmodule

// File: rtl/payload_rd_port.sv
module payload_rd_port
    import prp_pkg::*;
#(
    parameter int PKT_BITS = 272,
    parameter int PAY_BITS = 176
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pkt_load,
    input  logic [PKT_BITS-1:0] pkt_data,
    input  logic                cs_n,
    input  logic                rd_n,
    input  logic [3:0]          addr,
    input  logic                wide_sel,
    input  logic                rdy_mode,
    output logic [BUS_W-1:0]    data_out,
    output logic                rdy,
    output logic                drained
);
    localparam int PAY_BYTES = PAY_BITS / BYTE_W;
    localparam int PTR_W     = $clog2(PAY_BYTES + 1);

    logic             active;
    logic             advance;
    logic [PTR_W-1:0] ptr;

    prp_access_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .addr     (addr),
        .rdy_mode (rdy_mode),
        .active   (active),
        .advance  (advance),
        .rdy      (rdy)
    );

    prp_read_ptr #(.PAY_BYTES(PAY_BYTES), .PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pkt_load),
        .advance (advance),
        .wide    (wide_sel),
        .ptr     (ptr),
        .drained (drained)
    );

    prp_payload_store #(.PKT_BITS(PKT_BITS), .PAY_BITS(PAY_BITS), .PTR_W(PTR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pkt_load),
        .pkt_data (pkt_data),
        .ptr      (ptr),
        .wide     (wide_sel),
        .active   (active),
        .data_out (data_out)
    );

    AST_RESET_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> drained); // R1
endmodule

// File: tb/payload_rd_port_test.sv
`timescale 1ns/1ps
module payload_rd_port_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pkt_load = 1'b0;
    logic [271:0] pkt_data = '0;
    logic         cs_n = 1'b1;
    logic         rd_n = 1'b1;
    logic [3:0]   addr = 4'd0;
    logic         wide_sel = 1'b0;
    logic         rdy_mode = 1'b0;
    logic [15:0]  data_out;
    logic         rdy;
    logic         drained;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    logic [271:0] model_pkt;
    int           model_ptr;

    always #10 clk = ~clk;

    payload_rd_port uut (
        .clk(clk), .rst_n(rst_n), .pkt_load(pkt_load), .pkt_data(pkt_data),
        .cs_n(cs_n), .rd_n(rd_n), .addr(addr), .wide_sel(wide_sel),
        .rdy_mode(rdy_mode), .data_out(data_out), .rdy(rdy), .drained(drained)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input int k);
        if (k < 22) return model_pkt[271 - 8*k -: 8];
        return 8'h00;
    endfunction

    function automatic logic [15:0] exp_word(input bit w);
        if (w) return {pbyte(model_ptr), pbyte(model_ptr + 1)};
        return {8'h00, pbyte(model_ptr)};
    endfunction

    task automatic load_pkt(input logic [271:0] v);
        @(negedge clk);
        pkt_data = v; pkt_load = 1'b1;
        @(negedge clk);
        pkt_load = 1'b0;
        model_pkt = v; model_ptr = 0;
    endtask

    task automatic do_read(input bit w, input bit m);
        logic [15:0] e;
        @(negedge clk);
        wide_sel = w; rdy_mode = m; cs_n = 1'b0; addr = 4'd0; rd_n = 1'b0;
        e = exp_word(w);
        if (m) begin
            @(negedge clk);
            chk("R9 wait-state rdy low", {15'd0, rdy}, 16'd0);
        end
        @(negedge clk);
        chk("R9 rdy high", {15'd0, rdy}, 16'd1);
        chk(w ? "R4 wide data" : "R3 narrow data", data_out, e);
        rd_n = 1'b1;
        @(negedge clk);
        chk("R10 rdy falls", {15'd0, rdy}, 16'd0);
        cs_n = 1'b1;
        model_ptr = (model_ptr + (w ? 2 : 1) > 22) ? 22 : model_ptr + (w ? 2 : 1);
        chk("R7 drained flag", {15'd0, drained}, {15'd0, model_ptr == 22});
    endtask

    function automatic logic [271:0] make_pat(input int p);
        logic [271:0] v;
        v = '0;
        for (int k = 0; k < 34; k++) begin
            unique case (p)
                0: v[271 - 8*k -: 8] = (k < 22) ? 8'(k + 1) : 8'hFF;
                1: v[271 - 8*k -: 8] = 8'($urandom);
                2: v[271 - 8*k -: 8] = (k < 22) ? 8'h00 : 8'hFF;
                default: v[271 - 8*k -: 8] = k[0] ? 8'h5A : 8'hA5;
            endcase
        end
        return v;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset rdy", {15'd0, rdy}, 16'd0);
        chk("R1 reset data", data_out, 16'd0);
        chk("R1 reset drained", {15'd0, drained}, 16'd1);

        // R2 R3 R4 R6 R7 R9 R10: sweep patterns, widths and ready modes
        for (int p = 0; p < 4; p++) begin
            for (int w = 0; w < 2; w++) begin
                for (int m = 0; m < 2; m++) begin
                    load_pkt(make_pat(p));
                    chk("R8 drained cleared", {15'd0, drained}, 16'd0);
                    while (model_ptr < 22) do_read(w[0], m[0]);
                    do_read(w[0], m[0]);
                    do_read(w[0], m[0]);
                end
            end
        end

        // R5: accesses with a non-zero address or chip select high are ignored
        load_pkt(make_pat(0));
        @(negedge clk);
        cs_n = 1'b0; addr = 4'd4; rd_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R5 other address rdy", {15'd0, rdy}, 16'd0);
        chk("R5 other address data", data_out, 16'd0);
        rd_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; addr = 4'd0; rd_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R5 cs high rdy", {15'd0, rdy}, 16'd0);
        chk("R5 cs high data", data_out, 16'd0);
        rd_n = 1'b1;
        do_read(1'b0, 1'b0);

        // R4 R6: odd pointer then wide reads to the end
        load_pkt(make_pat(1));
        do_read(1'b0, 1'b0);
        while (model_ptr < 22) do_read(1'b1, 1'b1);

        // R8: a load in mid-stream rewinds the pointer
        load_pkt(make_pat(3));
        repeat (3) do_read(1'b0, 1'b0);
        load_pkt(make_pat(0));
        chk("R8 reload drained", {15'd0, drained}, 16'd0);
        do_read(1'b1, 1'b0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule